// File: doc/BRIEF.md
# Pad Function Multiplexer with General-Purpose I/O

This block controls the pads of one power domain: 32 pins split into three banks. Software programs it through a small synchronous read/write register bus. For each pad it produces four signals: the output level, the output enable, the bias enable and the bias polarity. A pad is either a general-purpose I/O, driven from the block's own direction and output registers, or it is taken over by an alternate-function group. Each group has one enable bit and owns a fixed set of pins. When a pin sits in several enabled groups, a fixed priority decides which group drives it. The pad input levels pass through a two-flop synchronizer and can be read back through the bus.

The pins do not each get their own register. A bank's pins occupy a contiguous run of bits, starting at a per-bank base bit, and two banks share one 32-bit word. The registers form five ranges, each two words long, at byte addresses of word index times four. A build parameter aliases the pull-enable range onto the pull-direction range, for pads that need only one bias control word.

Top module: `pmx_pad_ctrl`

## Requirements
- R1: After reset every group enable bit and every pull-enable bit is 0 and every direction bit is 1. All pads are therefore unbiased inputs: `pad_oe_o`, `pad_pull_en_o` and `pad_pull_up_o` are all zero. Direction words 0x14/0x18 read 0x0FFFFFFF/0x000000F0 and word 0x00 reads 0.
- R2: The registers are 32 bits wide, and the byte address is the word index times four. Group enables are at 0x00, pull-enable at 0x04/0x08, pull-direction at 0x0C/0x10, direction at 0x14/0x18, output at 0x1C/0x20 and input at 0x24/0x28. Read data appears on `bus_rdata_o` the cycle after `bus_rd_i` is sampled high.
- R3: Each pin's bit is its bank's base bit plus the pin number minus the bank's first pin. Pins 0-15 are in word 0 at bits 0-15, pins 16-27 are in word 0 at bits 16-27, and pins 28-31 are in word 1 at bits 4-7. The other bits of a range read 0.
- R4: A pin in GPIO mode with direction bit 1 is an input (`pad_oe_o`=0). With direction bit 0 the pin drives its output-register bit (`pad_oe_o`=1).
- R5: With its pull-enable bit clear, a pin has no bias. With the bit set, the pin's pull-direction bit selects pull-up (1) or pull-down (0). `pad_pull_up_o` is 1 only when the pull is enabled and pull-up is selected.
- R6: Group g is enabled by bit g of word 0x00 (bits 0-7). While a group is enabled, its pins take `alt_out_i`/`alt_oe_i` at index g*32+pin, and the GPIO direction and output registers have no effect on those pins.
- R7: A pin returns to GPIO control only once every group containing it is disabled. While any of its other groups is still enabled, that group keeps control of the pin.
- R8: When several enabled groups contain the same pin, the group with the lowest index drives it. The groups cover these pins: g0 pins 0-3, g1 pins 2-5, g2 pins 8-15, g3 pins 16-19, g4 pins 18-23, g5 pins 24-27, g6 pins 28-31, g7 pins 1, 9 and 30.
- R9: The input words return the pad level after two synchronizer flops, whatever the direction setting.
- R10: Writes to the input words, to unused words (0x2C-0x3C) and to unaligned addresses are ignored. Reads of unused words or unaligned addresses return 0.
- R11: With `SHARE_PULL`=1, addresses 0x04/0x08 reach the same storage as 0x0C/0x10. A set bit then means pull-up and a clear bit means no bias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 32 | Pad input levels (asynchronous) |
| alt_out_i | input | 256 | Alternate-function output values, index group*32+pin |
| alt_oe_i | input | 256 | Alternate-function output enables, index group*32+pin |
| pad_out_o | output | 32 | Pad output level |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pull_en_o | output | 32 | Pad bias enable |
| pad_pull_up_o | output | 32 | Pad bias polarity, 1 = pull-up |

## Verification
A fault in the bank bit mapping shows up at the pads as soon as the write's clock edge has passed: the wrong pad turns on its output enable or its bias. A wrong priority or a wrong ownership decision also appears in the same cycle, on `pad_out_o` and `pad_oe_o` of the overlapping pins. A fault in storage or in the read mux shows only on `bus_rdata_o`, one cycle after the read strobe. A synchronizer of the wrong depth changes when a new pad level first becomes visible in the input words.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NUM_PINS   = 32;
  localparam int NUM_GROUPS = 8;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int NUM_BANKS  = 3;

  localparam int BANK_FIRST [NUM_BANKS] = '{0, 16, 28};
  localparam int BANK_LAST  [NUM_BANKS] = '{15, 27, 31};
  localparam int BANK_WORD  [NUM_BANKS] = '{0, 0, 1};
  localparam int BANK_BIT   [NUM_BANKS] = '{0, 16, 4};

  localparam logic [NUM_PINS-1:0] GRP_MASK [NUM_GROUPS] = '{
    32'h0000_000F, 32'h0000_003C, 32'h0000_FF00, 32'h000F_0000,
    32'h00FC_0000, 32'h0F00_0000, 32'hF000_0000, 32'h4000_0202};

  function automatic int range_words();
    int m = 0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (BANK_WORD[b] > m) m = BANK_WORD[b];
    return m + 1;
  endfunction

  localparam int RANGE_WORDS = range_words();
  localparam int W_MUX = 0;
  localparam int W_PEN = 1;
  localparam int W_PUL = W_PEN + RANGE_WORDS;
  localparam int W_DIR = W_PUL + RANGE_WORDS;
  localparam int W_OUT = W_DIR + RANGE_WORDS;
  localparam int W_INP = W_OUT + RANGE_WORDS;
  localparam int W_END = W_INP + RANGE_WORDS;

  function automatic int pin_bank(int p);
    for (int b = 0; b < NUM_BANKS; b++)
      if (p >= BANK_FIRST[b] && p <= BANK_LAST[b]) return b;
    return 0;
  endfunction

  function automatic int pin_word(int p);
    return BANK_WORD[pin_bank(p)];
  endfunction

  function automatic logic [BIT_W-1:0] pin_bit(int p);
    int b;
    b = pin_bank(p);
    return BIT_W'(BANK_BIT[b] + p - BANK_FIRST[b]);
  endfunction
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter bit SHARE_PULL = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [NUM_GROUPS-1:0] grp_en_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [NUM_PINS-1:0]   pull_dir_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   out_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]     word;
  logic                  aligned;
  int                    wsel;
  logic [NUM_GROUPS-1:0] mux_q, mux_d;
  logic [NUM_PINS-1:0]   pe_q, pe_d, pu_q, pu_d, dir_q, dir_d, out_q, out_d;
  logic [DATA_W-1:0]     rd_word, rdata_q, rdata_d;

  assign word    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wsel    = int'(word);

  // next state for the configuration fields
  always_comb begin
    mux_d = mux_q;
    pe_d  = pe_q;
    pu_d  = pu_q;
    dir_d = dir_q;
    out_d = out_q;
    if (wr_i && aligned) begin
      if (wsel == W_MUX) mux_d = wdata_i[NUM_GROUPS-1:0];
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wsel == W_PEN + pin_word(p) || (SHARE_PULL && wsel == W_PUL + pin_word(p)))
          pe_d[p] = wdata_i[pin_bit(p)];
        if (wsel == W_PUL + pin_word(p) || (SHARE_PULL && wsel == W_PEN + pin_word(p)))
          pu_d[p] = wdata_i[pin_bit(p)];
        if (wsel == W_DIR + pin_word(p)) dir_d[p] = wdata_i[pin_bit(p)];
        if (wsel == W_OUT + pin_word(p)) out_d[p] = wdata_i[pin_bit(p)];
      end
    end
  end

  // read word assembly: each pin lands on its bank bit
  always_comb begin
    rd_word = '0;
    if (aligned) begin
      if (wsel == W_MUX) rd_word[NUM_GROUPS-1:0] = mux_q;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wsel == W_PEN + pin_word(p)) rd_word[pin_bit(p)] = pe_q[p];
        if (wsel == W_PUL + pin_word(p)) rd_word[pin_bit(p)] = pu_q[p];
        if (wsel == W_DIR + pin_word(p)) rd_word[pin_bit(p)] = dir_q[p];
        if (wsel == W_OUT + pin_word(p)) rd_word[pin_bit(p)] = out_q[p];
        if (wsel == W_INP + pin_word(p)) rd_word[pin_bit(p)] = pin_in_i[p];
      end
    end
    rdata_d = rd_i ? rd_word : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q   <= '0;
      pe_q    <= '0;
      pu_q    <= '0;
      dir_q   <= '1;
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      mux_q   <= mux_d;
      pe_q    <= pe_d;
      pu_q    <= pu_d;
      dir_q   <= dir_d;
      out_q   <= out_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign grp_en_o   = mux_q;
  assign pull_en_o  = pe_q;
  assign pull_dir_o = pu_q;
  assign dir_o      = dir_q;
  assign out_o      = out_q;

  // R10: a read of an unused word or an unaligned address returns zero
  p_unused_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (wsel >= W_END || !aligned)) |=> (rdata_o == '0));

  // R2: a read with no strobe leaves the returned data unchanged
  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pmx_pad_mux.sv
module pmx_pad_mux
  import pmx_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_GROUPS-1:0]          grp_en_i,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] alt_oe_i,
  input  logic [NUM_PINS-1:0]            dir_i,
  input  logic [NUM_PINS-1:0]            out_i,
  output logic [NUM_PINS-1:0]            pad_out_o,
  output logic [NUM_PINS-1:0]            pad_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // walk from highest to lowest index so the lowest enabled group wins
    always_comb begin
      pad_out_o[p] = out_i[p];
      pad_oe_o[p]  = ~dir_i[p];
      for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
        if (grp_en_i[g] && GRP_MASK[g][p]) begin
          pad_out_o[p] = alt_out_i[g*NUM_PINS + p];
          pad_oe_o[p]  = alt_oe_i[g*NUM_PINS + p];
        end
      end
    end
  end

  // R7: with no group enabled every pad follows the GPIO registers
  p_gpio_fallback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_en_i == '0) |-> (pad_oe_o == ~dir_i && pad_out_o == out_i));

  // R8: group 0 has top priority on every pin it owns
  p_group0_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_en_i[0] |-> (((pad_out_o ^ alt_out_i[NUM_PINS-1:0]) & GRP_MASK[0]) == '0));
endmodule

// File: rtl/pmx_pad_ctrl.sv
module pmx_pad_ctrl
  import pmx_pkg::*;
#(
  parameter bit SHARE_PULL = 1'b0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_wr_i,
  input  logic                           bus_rd_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  input  logic [NUM_PINS-1:0]            pad_in_i,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_GROUPS*NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0]            pad_out_o,
  output logic [NUM_PINS-1:0]            pad_oe_o,
  output logic [NUM_PINS-1:0]            pad_pull_en_o,
  output logic [NUM_PINS-1:0]            pad_pull_up_o
);
  logic [1:0]            rst_q;
  logic                  rst_n;
  logic [NUM_PINS-1:0]   pin_in;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [NUM_PINS-1:0]   pull_en, pull_dir, dir, out;

  // reset asserts at once and is released on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  pmx_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (pad_in_i),
    .q_o   (pin_in)
  );

  pmx_regfile #(.SHARE_PULL(SHARE_PULL)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .pin_in_i  (pin_in),
    .grp_en_o  (grp_en),
    .pull_en_o (pull_en),
    .pull_dir_o(pull_dir),
    .dir_o     (dir),
    .out_o     (out)
  );

  pmx_pad_mux u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .grp_en_i (grp_en),
    .alt_out_i(alt_out_i),
    .alt_oe_i (alt_oe_i),
    .dir_i    (dir),
    .out_i    (out),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  assign pad_pull_en_o = pull_en;
  assign pad_pull_up_o = pull_en & pull_dir;

  // R5: pull-up is never signalled on a pad without bias enabled
  p_pullup_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pad_pull_up_o & ~pad_pull_en_o) == '0));
endmodule

// File: tb/pmx_pad_ctrl_tb.sv
module pmx_pad_ctrl_tb;
  import pmx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata, rdata_sh;
  logic [NUM_PINS-1:0] pad_in = '0;
  logic [NUM_GROUPS*NUM_PINS-1:0] alt_out = '0, alt_oe = '0;
  logic [NUM_PINS-1:0] pout, poe, ppe, ppu;
  logic [NUM_PINS-1:0] pout_s, poe_s, ppe_s, ppu_s;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] got, got_sh;

  always #2.5 clk = ~clk;

  pmx_pad_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pad_out_o(pout), .pad_oe_o(poe), .pad_pull_en_o(ppe), .pad_pull_up_o(ppu));

  pmx_pad_ctrl #(.SHARE_PULL(1'b1)) u_dut_sh (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_sh),
    .pad_in_i(pad_in), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pad_out_o(pout_s), .pad_oe_o(poe_s), .pad_pull_en_o(ppe_s), .pad_pull_up_o(ppu_s));

  // {address, write data, expected read-back}
  localparam int NV = 10;
  localparam logic [69:0] VEC [NV] = '{
    {6'h1C, 32'hFFFF_FFFF, 32'h0FFF_FFFF},
    {6'h20, 32'hFFFF_FFFF, 32'h0000_00F0},
    {6'h1C, 32'h1234_5678, 32'h0234_5678},
    {6'h0C, 32'hA5A5_A5A5, 32'h05A5_A5A5},
    {6'h10, 32'h0000_00A0, 32'h0000_00A0},
    {6'h00, 32'h0000_01FF, 32'h0000_00FF},
    {6'h00, 32'h0000_0000, 32'h0000_0000},
    {6'h2C, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'h04, 32'h0000_FFFF, 32'h0000_FFFF},
    {6'h04, 32'h0000_0000, 32'h0000_0000}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    got = rdata; got_sh = rdata_sh;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe", poe, 32'h0);
    check("R1 pull_en", ppe, 32'h0);
    check("R1 pull_up", ppu, 32'h0);
    bus_read(6'h14); check("R1 dir0", got, 32'h0FFF_FFFF);
    bus_read(6'h18); check("R1 dir1", got, 32'h0000_00F0);
    bus_read(6'h00); check("R1 mux", got, 32'h0);

    // R2 R3 R10 table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][69:64], VEC[i][63:32]);
      bus_read(VEC[i][69:64]);
      check("R2/R3 vec", got, VEC[i][31:0]);
    end
    bus_write(6'h1C, 0); bus_write(6'h20, 0);
    bus_write(6'h0C, 0); bus_write(6'h10, 0);

    // R4 direction and output, pins 5, 20, 30
    bus_write(6'h14, 32'h0FEF_FFDF);
    bus_write(6'h1C, 32'h0000_0020);
    check("R4 oe5", poe[5], 1); check("R4 out5", pout[5], 1);
    check("R4 oe20", poe[20], 1); check("R4 out20", pout[20], 0);
    check("R4 oe6 input", poe[6], 0);
    bus_write(6'h18, 32'h0000_00B0);
    bus_write(6'h20, 32'h0000_0040);
    check("R3 oe30", poe[30], 1); check("R3 out30", pout[30], 1);
    check("R3 oe28", poe[28], 0);

    // R5 bias
    bus_write(6'h04, 32'h0000_0020);
    check("R5 pe5", ppe[5], 1); check("R5 pulldown5", ppu[5], 0);
    bus_write(6'h0C, 32'h0000_0020);
    check("R5 pu5", ppu[5], 1);
    bus_write(6'h08, 32'h0000_0020);
    check("R5 pe29", ppe[29], 1); check("R5 pu29", ppu[29], 0);

    // R11 aliased pull ranges on the second instance
    check("R11 sh pe29", ppe_s[29], 1); check("R11 sh pu29", ppu_s[29], 1);
    bus_write(6'h04, 32'h0);
    check("R11 sh pe5 cleared", ppe_s[5], 0);
    check("R5 pe5 cleared", ppe[5], 0); check("R5 pu5 no bias", ppu[5], 0);
    bus_read(6'h0C);
    check("R11 sh pull word", got_sh, 32'h0);
    check("R5 pull word kept", got, 32'h0000_0020);

    // R6 group 1 takes pin 5 from GPIO
    alt_out[1*32+5] = 1'b0; alt_oe[1*32+5] = 1'b1;
    bus_write(6'h00, 32'h02);
    check("R6 out5 alt", pout[5], 0); check("R6 oe5 alt", poe[5], 1);
    bus_write(6'h1C, 32'h0); bus_write(6'h14, 32'h0FFF_FFFF);
    check("R6 gpio ignored oe5", poe[5], 1);

    // R8 priority on overlapping pins
    alt_out[0*32+3] = 1'b1; alt_oe[0*32+3] = 1'b1;
    alt_out[1*32+3] = 1'b0; alt_oe[1*32+3] = 1'b0;
    bus_write(6'h00, 32'h03);
    check("R8 out3 g0", pout[3], 1); check("R8 oe3 g0", poe[3], 1);
    alt_out[6*32+30] = 1'b0; alt_oe[6*32+30] = 1'b1;
    alt_out[7*32+30] = 1'b1; alt_oe[7*32+30] = 1'b1;
    bus_write(6'h00, 32'hC0);
    check("R8 out30 g6", pout[30], 0);

    // R7 fallback
    bus_write(6'h00, 32'h80);
    check("R7 out30 g7", pout[30], 1);
    bus_write(6'h00, 32'h02);
    check("R7 oe3 g1", poe[3], 0);
    bus_write(6'h00, 32'h00);
    check("R7 oe3 gpio", poe[3], 0); check("R7 oe5 gpio", poe[5], 0);
    check("R7 oe30 gpio", poe[30], 1); check("R7 out30 gpio", pout[30], 1);

    // R9 input sampling
    @(negedge clk); pad_in = 32'hA5C3_0F96;
    repeat (3) @(negedge clk);
    bus_read(6'h24); check("R9 in0", got, 32'h05C3_0F96);
    bus_read(6'h28); check("R9 in1 pin30 level", got, 32'h0000_00A0);

    // R10 ignored writes
    bus_write(6'h24, 32'h0);
    bus_read(6'h24); check("R10 in readonly", got, 32'h05C3_0F96);
    bus_write(6'h3C, 32'hFFFF_FFFF);
    check("R10 unused write pads", poe, 32'h4000_0000);
    bus_read(6'h3C); check("R10 unused read", got, 32'h0);
    bus_write(6'h15, 32'h0);
    bus_read(6'h14); check("R10 unaligned write", got, 32'h0FFF_FFFF);
    bus_read(6'h15); check("R10 unaligned read", got, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule